// File: doc/BRIEF.md
# Masked-write GPIO bank

This block is one bank of general-purpose pins, up to 32 wide, behind a small memory-mapped register port made of an address, write data, a write strobe and read data. The bank stores the output values, the direction bits and the output-enable bits. It drives the pin values and the tri-state enables, and it brings the pin inputs in through a synchronizer.

Software changes output values through two half-word write ports, one for the low sixteen pins and one for the high sixteen. Each written word carries a protect mask in its upper half and new data in its lower half. Only the unprotected pins take the new value. Several agents can therefore change their own pins with a single write, with no read-modify-write and no risk of overwriting each other's pins.

A parameter sets how many pins the bank implements. Bits above that count are tied to zero. A second parameter, the bank index, places the register addresses inside a shared address map.

Top module: `gpio_bank`

## Requirements
- R1: After a cycle with `rst` high, the output values, the direction bits and the output-enable bits are all 0, so `pin_out` and `pin_oe` are 0 and every pin is an undriven input; `rdata` is also 0.
- R2: A write to the low-half port at byte offset 8*BANK updates output bits 15:0. Write-data bits 31:16 form a mask: a mask bit of 1 leaves the matching output bit unchanged, and a mask bit of 0 loads the matching bit of write-data 15:0. The change appears on `pin_out` one cycle after the write.
- R3: A write to the high-half port at offset 4+8*BANK applies the same mask and data rule to output bits 31:16. Mask bit k and data bit k both map to pin 16+k.
- R4: Reads of either half-word port return 0. Reads of any address the bank does not decode also return 0, and writes to such addresses change nothing.
- R5: The direction register at offset 0x204+0x40*BANK is read/write. A bit value of 1 selects output and 0 selects input.
- R6: The output-enable register at offset 0x208+0x40*BANK is read/write. `pin_oe[n]` is 1 only when direction bit n and output-enable bit n are both 1. `pin_oe` does not change unless one of these two registers is written.
- R7: The input register at offset 0x060+4*BANK is read-only, and its bit n is pin n. Pin inputs pass through two flops. `rdata` is registered one cycle after the address is presented, so a pin change set up before clock edge k is visible in `rdata` after edge k+2.
- R8: Bits at index NPINS and above read as 0 in every register, ignore writes, and hold `pin_out` and `pin_oe` at 0.
- R9: Decoding uses only the word address: address bits 1:0 are ignored for both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | Byte address of the register access |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rdata | output | 32 | Registered read data for the previous cycle's address |
| pin_in | input | 32 | Raw pin input levels |
| pin_out | output | 32 | Output values driven to the pins |
| pin_oe | output | 32 | Tri-state enables, 1 = drive |

## Verification
The mask and data writes are tried with three kinds of word. A zero mask loads a whole half. A mask that protects all but one bit shows that single pins change atomically and that neighbouring pins keep their values. Writes to the high half on a 22-pin bank show that the unimplemented pins stay tied off. Direction and output-enable are written with differing patterns, so that any gate other than AND shows up on `pin_oe`. The input path is probed edge by edge to pin down its latency. Misaligned addresses and undecoded addresses separate correct word decoding from aliasing.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int HALF = 16;

  function automatic int ofs_lo(input int bank);
    return 8 * bank;
  endfunction
  function automatic int ofs_hi(input int bank);
    return 4 + 8 * bank;
  endfunction
  function automatic int ofs_in(input int bank);
    return 32'h060 + 4 * bank;
  endfunction
  function automatic int ofs_dir(input int bank);
    return 32'h204 + 32'h40 * bank;
  endfunction
  function automatic int ofs_oen(input int bank);
    return 32'h208 + 32'h40 * bank;
  endfunction

  typedef enum logic [2:0] {
    SEL_NONE, SEL_LO, SEL_HI, SEL_IN, SEL_DIR, SEL_OEN
  } sel_e;
endpackage

// File: rtl/gpio_insync.sv
module gpio_insync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_maskhalf.sv
module gpio_maskhalf #(
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [HW-1:0] keep,
  input  logic [HW-1:0] din,
  input  logic [HW-1:0] impl,
  output logic [HW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (we) q <= ((q & keep) | (din & ~keep)) & impl;
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int AW    = 12,
  parameter int NPINS = 32,
  parameter int BANK  = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  input  logic          wr_en,
  output logic [31:0]   rdata,
  input  logic [31:0]   pin_in,
  output logic [31:0]   pin_out,
  output logic [31:0]   pin_oe
);
  import gpio_bank_pkg::*;

  localparam int NHALF = 32 / HALF;
  localparam logic [31:0] IMPL = (NPINS >= 32) ? 32'hFFFF_FFFF
                                               : ((32'h1 << NPINS) - 32'h1);
  localparam logic [AW-3:0] W_LO  = AW'(ofs_lo(BANK))  >> 2;
  localparam logic [AW-3:0] W_HI  = AW'(ofs_hi(BANK))  >> 2;
  localparam logic [AW-3:0] W_IN  = AW'(ofs_in(BANK))  >> 2;
  localparam logic [AW-3:0] W_DIR = AW'(ofs_dir(BANK)) >> 2;
  localparam logic [AW-3:0] W_OEN = AW'(ofs_oen(BANK)) >> 2;

  logic [AW-3:0] waddr;
  sel_e          sel;
  logic [31:0]   dir_q, oen_q, in_sync;

  assign waddr = addr[AW-1:2];

  always_comb begin
    if      (waddr == W_LO)  sel = SEL_LO;
    else if (waddr == W_HI)  sel = SEL_HI;
    else if (waddr == W_IN)  sel = SEL_IN;
    else if (waddr == W_DIR) sel = SEL_DIR;
    else if (waddr == W_OEN) sel = SEL_OEN;
    else                     sel = SEL_NONE;
  end

  genvar h;
  generate
    for (h = 0; h < NHALF; h++) begin : g_half
      logic we_h;
      assign we_h = wr_en && (sel == ((h == 0) ? SEL_LO : SEL_HI));
      gpio_maskhalf #(.HW(HALF)) u_half (
        .clk (clk),
        .rst (rst),
        .we  (we_h),
        .keep(wdata[31:16]),
        .din (wdata[15:0]),
        .impl(IMPL[h*HALF +: HALF]),
        .q   (pin_out[h*HALF +: HALF])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      oen_q <= '0;
    end else if (wr_en) begin
      if (sel == SEL_DIR) dir_q <= wdata & IMPL;
      if (sel == SEL_OEN) oen_q <= wdata & IMPL;
    end
  end

  assign pin_oe = dir_q & oen_q;

  gpio_insync #(.W(32)) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (pin_in),
    .q  (in_sync)
  );

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      case (sel)
        SEL_IN:  rdata <= in_sync & IMPL;
        SEL_DIR: rdata <= dir_q;
        SEL_OEN: rdata <= oen_q;
        default: rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int AW    = 12,
  parameter int NPINS = 32,
  parameter int BANK  = 0
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] addr,
  input logic [31:0]   wdata,
  input logic          wr_en,
  input logic [31:0]   rdata,
  input logic [31:0]   pin_out,
  input logic [31:0]   pin_oe
);
  import gpio_bank_pkg::*;
  localparam logic [31:0] IMPL = (NPINS >= 32) ? 32'hFFFF_FFFF
                                               : ((32'h1 << NPINS) - 32'h1);
  localparam logic [AW-3:0] W_LO  = AW'(ofs_lo(BANK))  >> 2;
  localparam logic [AW-3:0] W_HI  = AW'(ofs_hi(BANK))  >> 2;
  localparam logic [AW-3:0] W_DIR = AW'(ofs_dir(BANK)) >> 2;
  localparam logic [AW-3:0] W_OEN = AW'(ofs_oen(BANK)) >> 2;

  logic hit_lo, hit_hi, hit_cfg;
  assign hit_lo  = addr[AW-1:2] == W_LO;
  assign hit_hi  = addr[AW-1:2] == W_HI;
  assign hit_cfg = (addr[AW-1:2] == W_DIR) || (addr[AW-1:2] == W_OEN);

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (pin_out == 32'h0 && pin_oe == 32'h0 && rdata == 32'h0));

  a_r2_lo_protect: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit_lo) |=>
      (((pin_out[15:0] ^ $past(pin_out[15:0])) & $past(wdata[31:16])) == 16'h0));

  a_r3_hi_protect: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit_hi) |=>
      (((pin_out[31:16] ^ $past(pin_out[31:16])) & $past(wdata[31:16])) == 16'h0));

  a_r4_half_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (hit_lo || hit_hi) |=> (rdata == 32'h0));

  a_r6_oe_stable: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && hit_cfg) |=> $stable(pin_oe));

  a_r8_tied_off: assert property (@(posedge clk) disable iff (rst)
    ((pin_out | pin_oe | rdata) & ~IMPL) == 32'h0);
endmodule

bind gpio_bank gpio_bank_chk #(.AW(AW), .NPINS(NPINS), .BANK(BANK)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .addr   (addr),
  .wdata  (wdata),
  .wr_en  (wr_en),
  .rdata  (rdata),
  .pin_out(pin_out),
  .pin_oe (pin_oe)
);

// File: tb/gpio_bank_test.sv
module gpio_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int NP = 22;
  localparam int BK = 1;
  localparam logic [31:0] IMPL = (32'h1 << NP) - 32'h1;
  localparam int A_LO = 8 * BK, A_HI = 4 + 8 * BK, A_IN = 'h60 + 4 * BK;
  localparam int A_DIR = 'h204 + 'h40 * BK, A_OEN = 'h208 + 'h40 * BK;

  logic clk = 0, rst = 1, wr_en = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, pin_in = '0;
  logic [31:0] rdata, pin_out, pin_oe;

  int nvec = 0, nbad = 0;
  bit done = 0;
  string tag = "R1";

  logic [31:0] m_out = 0, m_dir = 0, m_oen = 0, m_s1 = 0, m_s2 = 0, m_rd = 0;

  gpio_bank #(.AW(AW), .NPINS(NP), .BANK(BK)) uut (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference, updated at every edge
  always @(posedge clk) begin
    int wa;
    wa = int'(addr) & ~3;
    if (rst) begin
      m_out <= 0; m_dir <= 0; m_oen <= 0; m_s1 <= 0; m_s2 <= 0; m_rd <= 0;
    end else begin
      m_s1 <= pin_in;
      m_s2 <= m_s1;
      if (wa == A_IN) m_rd <= m_s2 & IMPL;
      else if (wa == A_DIR) m_rd <= m_dir;
      else if (wa == A_OEN) m_rd <= m_oen;
      else m_rd <= 0;
      if (wr_en) begin
        for (int i = 0; i < 16; i++) begin
          if (wa == A_LO && !wdata[16+i] && i < NP) m_out[i] <= wdata[i];
          if (wa == A_HI && !wdata[16+i] && 16+i < NP) m_out[16+i] <= wdata[i];
        end
        if (wa == A_DIR) m_dir <= wdata & IMPL;
        if (wa == A_OEN) m_oen <= wdata & IMPL;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (!done) begin
      nvec++;
      if (pin_out !== m_out || pin_oe !== (m_dir & m_oen) || rdata !== m_rd) begin
        nbad++;
        $display("FAIL %s cycle compare: out=%h oe=%h rd=%h expected out=%h oe=%h rd=%h",
                 tag, pin_out, pin_oe, rdata, m_out, m_dir & m_oen, m_rd);
      end
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); addr = AW'(a); wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0; addr = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk); addr = AW'(a);
    @(posedge clk); #2; v = rdata;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    #2;
    tag = "R1";
    chk("R1 pin_out", pin_out, 0);
    chk("R1 pin_oe", pin_oe, 0);
    chk("R1 rdata", rdata, 0);

    tag = "R2";
    wr(A_LO, 32'h0000_A5A5);
    chk("R2 full low load", pin_out, 32'h0000_A5A5);
    wr(A_LO, 32'hFFFE_0000);
    chk("R2 single pin clear", pin_out, 32'h0000_A5A4);
    wr(A_LO, 32'hFF7F_FFFF);
    chk("R2 single pin set", pin_out, 32'h0000_A5A4 | 32'h80);

    tag = "R3";
    wr(A_HI, 32'h0000_FFFF);
    chk("R3 R8 high load tied", pin_out, 32'h003F_A524 | 32'h80);
    wr(A_HI, 32'hFFFD_0000);
    chk("R3 pin17 clear", pin_out, 32'h003D_A5A4);

    tag = "R4";
    rd(A_LO, v); chk("R4 low port reads 0", v, 0);
    rd(A_HI, v); chk("R4 high port reads 0", v, 0);
    wr('h100, 32'hFFFF_FFFF);
    rd('h100, v); chk("R4 undecoded reads 0", v, 0);
    chk("R4 undecoded write no effect", pin_out, 32'h003D_A5A4);

    tag = "R5";
    wr(A_DIR, 32'hFFFF_FFFF);
    rd(A_DIR, v); chk("R5 R8 dir readback", v, IMPL);
    chk("R6 oe off with oen 0", pin_oe, 0);

    tag = "R6";
    wr(A_OEN, 32'h00F0_FF0F);
    rd(A_OEN, v); chk("R6 oen readback", v, 32'h0030_FF0F);
    chk("R6 oe is and", pin_oe, 32'h0030_FF0F);
    wr(A_DIR, 32'h0000_00FF);
    chk("R6 oe after dir change", pin_oe, 32'h0000_000F);

    tag = "R7";
    @(negedge clk); addr = AW'(A_IN); pin_in = 32'hFFFF_FFFF;
    @(posedge clk); #2; chk("R7 edge1 old", rdata, 0);
    @(posedge clk); #2; chk("R7 edge2 old", rdata, 0);
    @(posedge clk); #2; chk("R7 edge3 new R8 masked", rdata, IMPL);
    @(negedge clk); pin_in = 32'h0012_3456;
    repeat (3) @(posedge clk); #2;
    chk("R7 pattern", rdata, 32'h0012_3456);

    tag = "R9";
    rd(A_DIR + 2, v); chk("R9 misaligned read", v, 32'h0000_00FF);
    wr(A_OEN + 3, 32'h0000_0003);
    chk("R9 misaligned write", pin_oe, 32'h0000_0003);
    wr(A_LO + 1, 32'h0000_0000);
    chk("R9 misaligned half write", pin_out, 32'h003D_0000);

    tag = "R1";
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0; #2;
    chk("R1 reset out", pin_out, 0);
    chk("R1 reset oe", pin_oe, 0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      nbad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule